// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a synthesizer loop has locked by timing the phase error at its phase-frequency detector in the digital domain. It sees two single-cycle edge pulses, one from the reference path and one from the divided feedback path, both already synchronous to a fast measurement clock. Each comparison cycle, it counts measurement-clock cycles from whichever edge arrives first to its partner. That count is the phase error for the cycle.

The error counts are judged against two thresholds, which are set in nanoseconds and converted to counts from the measurement clock frequency. The indicator rises only after a run of consecutive small-error cycles. Once high, it stays high through moderate errors and falls on the first cycle whose error reaches the larger threshold. With the defaults (400 MHz, 15 ns, 25 ns, a run of five) the thresholds are 6 and 10 counts.

A missing partner edge ends the measurement with a saturated error, which counts as a loss of lock. So does a leading edge that repeats before its partner.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is asserted and after its release, `lock` is 0 until a qualifying run of samples has been seen.
- R2: The phase error of a comparison is the number of measurement-clock rising edges from the one that samples the first-arriving pulse to the one that samples its partner. It is the same whichever input leads, and 0 when both pulses are sampled on the same edge.
- R3: Thresholds are ns × clock MHz / 1000, rounded down. By default a sample is small when its error is below 6 and large when its error is 10 or more.
- R4: While unlocked, `lock` rises on the fifth consecutive small sample. It becomes visible one clock after the edge that completes that sample.
- R5: While unlocked, any sample that is not small clears the run of small samples, so five further small samples are needed.
- R6: While locked, samples with errors below 10, including those from 6 to 9, leave `lock` high.
- R7: While locked, a single large sample drops `lock` one clock after the edge that completes it.
- R8: If no partner arrives within TIMEOUT_CYC (default 63) cycles of the leading pulse, the measurement ends with a saturated error of TIMEOUT_CYC, which counts as large. The detector then waits for a new leading pulse.
- R9: A repeat of the leading pulse before the partner arrives produces a saturated, large sample. A new measurement starts from the repeated pulse.
- R10: `lock` changes only on the clock after a completed sample.
- R11: After lock is lost, it is regained only after five new consecutive small samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_pulse | input | 1 | One-cycle pulse marking a reference edge |
| fb_pulse | input | 1 | One-cycle pulse marking a feedback edge |
| lock | output | 1 | Digital lock indicator |

## Verification
Several properties are checked on every cycle. The indicator may rise only after a small sample and fall only after a large one, and it holds when no sample completes. The run counter stays bounded, a coincident pair of pulses yields a zero error, and an expired wait yields a saturated sample. The bench scenarios cover the rest: the exact error count for each lead order, the fifth-sample lock point, the run reset from a middling sample, the band between thresholds that keeps lock, and the timeout and repeated-lead cases. These need whole sequences of comparisons against a reference model.

// File: rtl/ld_pkg.sv
package ld_pkg;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } meter_st_t;

  function automatic int ns_to_counts(input int ns, input int clk_mhz);
    return (ns * clk_mhz) / 1000;
  endfunction

endpackage

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
  import ld_pkg::*;
#(
  parameter int TIMEOUT_CYC = 63,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             samp_v,
  output logic [CNT_W-1:0] samp_err
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  meter_st_t        st_q, st_n;
  logic             lead_fb_q, lead_fb_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             v_n;
  logic [CNT_W-1:0] err_n;
  logic             partner, again;

  assign partner = lead_fb_q ? ref_pulse : fb_pulse;
  assign again   = lead_fb_q ? fb_pulse  : ref_pulse;

  always_comb begin
    st_n      = st_q;
    lead_fb_n = lead_fb_q;
    cnt_n     = cnt_q;
    v_n       = 1'b0;
    err_n     = samp_err;
    case (st_q)
      MS_IDLE: begin
        if (ref_pulse && fb_pulse) begin
          v_n   = 1'b1;
          err_n = '0;
        end else if (ref_pulse || fb_pulse) begin
          st_n      = MS_WAIT;
          lead_fb_n = fb_pulse;
          cnt_n     = ONE_CNT;
        end
      end
      MS_WAIT: begin
        if (partner) begin
          v_n   = 1'b1;
          err_n = cnt_q;
          st_n  = MS_IDLE;
        end else if (again) begin
          v_n   = 1'b1;
          err_n = MAX_CNT;
          cnt_n = ONE_CNT;
        end else if (cnt_q == MAX_CNT) begin
          v_n   = 1'b1;
          err_n = MAX_CNT;
          st_n  = MS_IDLE;
        end else begin
          cnt_n = cnt_q + ONE_CNT;
        end
      end
      default: st_n = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= MS_IDLE;
      lead_fb_q <= 1'b0;
      cnt_q     <= '0;
      samp_v    <= 1'b0;
      samp_err  <= '0;
    end else begin
      st_q      <= st_n;
      lead_fb_q <= lead_fb_n;
      cnt_q     <= cnt_n;
      samp_v    <= v_n;
      if (v_n) samp_err <= err_n;
    end
  end

  assert_zero_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_IDLE && ref_pulse && fb_pulse) |=> (samp_v && samp_err == '0));

  assert_timeout_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_WAIT && cnt_q == MAX_CNT && !ref_pulse && !fb_pulse)
      |=> (samp_v && samp_err == MAX_CNT && st_q == MS_IDLE));

  assert_repeat_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_WAIT && again && !partner)
      |=> (samp_v && samp_err == MAX_CNT && st_q == MS_WAIT && cnt_q == ONE_CNT));

endmodule

// File: rtl/ld_err_judge.sv
module ld_err_judge #(
  parameter int CNT_W     = 6,
  parameter int LOCK_CNT  = 6,
  parameter int UNLOCK_CNT = 10
) (
  input  logic [CNT_W-1:0] err,
  output logic             small_err,
  output logic             large_err
);

  localparam logic [CNT_W-1:0] LOCK_TH   = CNT_W'(LOCK_CNT);
  localparam logic [CNT_W-1:0] UNLOCK_TH = CNT_W'(UNLOCK_CNT);

  always_comb begin
    small_err = (err < LOCK_TH);
    large_err = (err >= UNLOCK_TH);
  end

endmodule

// File: rtl/ld_lock_fsm.sv
module ld_lock_fsm #(
  parameter int GOOD_RUN = 5,
  parameter int RUN_W    = $clog2(GOOD_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_v,
  input  logic small_err,
  input  logic large_err,
  output logic lock
);

  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(GOOD_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(GOOD_RUN);

  logic [RUN_W-1:0] run_q, run_n;
  logic             lock_n;

  always_comb begin
    run_n  = run_q;
    lock_n = lock;
    if (samp_v) begin
      if (!lock) begin
        if (small_err) begin
          if (run_q == LAST_RUN) begin
            lock_n = 1'b1;
            run_n  = '0;
          end else begin
            run_n = run_q + 1'b1;
          end
        end else begin
          run_n = '0;
        end
      end else if (large_err) begin
        lock_n = 1'b0;
        run_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lock  <= 1'b0;
    end else begin
      run_q <= run_n;
      lock  <= lock_n;
    end
  end

  assert_lock_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(samp_v && small_err));

  assert_lock_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(samp_v && large_err));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_v |=> $stable(lock));

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_MAX);

  assert_band_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && samp_v && !large_err) |=> lock);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import ld_pkg::*;
#(
  parameter int MEAS_CLK_MHZ = 400,
  parameter int LOCK_NS      = 15,
  parameter int UNLOCK_NS    = 25,
  parameter int GOOD_RUN     = 5,
  parameter int TIMEOUT_CYC  = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic lock
);

  localparam int LOCK_CNT   = ns_to_counts(LOCK_NS, MEAS_CLK_MHZ);
  localparam int UNLOCK_CNT = ns_to_counts(UNLOCK_NS, MEAS_CLK_MHZ);
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1);
  localparam int RUN_W      = $clog2(GOOD_RUN + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             samp_v;
  logic [CNT_W-1:0] samp_err;
  logic             small_err, large_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ld_phase_meter #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .samp_v    (samp_v),
    .samp_err  (samp_err)
  );

  ld_err_judge #(
    .CNT_W      (CNT_W),
    .LOCK_CNT   (LOCK_CNT),
    .UNLOCK_CNT (UNLOCK_CNT)
  ) u_judge (
    .err       (samp_err),
    .small_err (small_err),
    .large_err (large_err)
  );

  ld_lock_fsm #(
    .GOOD_RUN (GOOD_RUN),
    .RUN_W    (RUN_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .samp_v    (samp_v),
    .small_err (small_err),
    .large_err (large_err),
    .lock      (lock)
  );

  assert_reset_unlocked_R1: assert property (@(posedge clk)
    !rst_int_n |-> !lock);

  assert_saturated_is_large_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (samp_v && samp_err == CNT_W'(TIMEOUT_CYC)) |-> large_err);

endmodule

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0;
  logic fb_p = 1'b0;
  logic lock;

  always #5 clk = ~clk;

  pll_lock_detect uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_p),
    .fb_pulse  (fb_p),
    .lock      (lock)
  );

  localparam int TMO = 63;

  typedef struct {
    int    at;
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  logic  m_lock = 1'b0;
  int    m_run = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(input int err);
    if (!m_lock) begin
      if (err < 6) begin
        m_run++;
        if (m_run == 5) begin
          m_lock = 1'b1;
          m_run  = 0;
        end
      end else begin
        m_run = 0;
      end
    end else if (err >= 10) begin
      m_lock = 1'b0;
      m_run  = 0;
    end
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.at  = cyc + 1;
    it.exp = m_lock;
    it.tag = tag;
    q.push_back(it);
  endtask

  // one comparison; k = cycles between edges
  task automatic compare(input bit ref_first, input int k, input string tag);
    @(negedge clk);
    if (k == 0) begin
      ref_p = 1'b1; fb_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0; fb_p = 1'b0;
    end else begin
      if (ref_first) ref_p = 1'b1; else fb_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0; fb_p = 1'b0;
      repeat (k - 1) @(negedge clk);
      if (ref_first) fb_p = 1'b1; else ref_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0; fb_p = 1'b0;
    end
    model(k);
    push(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic lone_edge(input string tag);
    @(negedge clk);
    ref_p = 1'b1;
    @(negedge clk);
    ref_p = 1'b0;
    repeat (TMO) @(negedge clk);
    model(TMO);
    push(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic repeat_lead(input string tag);
    @(negedge clk);
    ref_p = 1'b1;
    @(negedge clk);
    ref_p = 1'b0;
    repeat (2) @(negedge clk);
    ref_p = 1'b1;
    @(negedge clk);
    ref_p = 1'b0;
    model(TMO);
    push({tag, " repeat"});
    @(negedge clk);
    fb_p = 1'b1;
    @(negedge clk);
    fb_p = 1'b0;
    model(2);
    push({tag, " restart err=2"});
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected items and compares with the port
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].at <= cyc) begin
        it = q.pop_front();
        total++;
        if (it.at != cyc || lock !== it.exp) begin
          bad++;
          $display("FAIL %s: lock=%b expected=%b (cycle %0d vs %0d)",
                   it.tag, lock, it.exp, cyc, it.at);
        end
      end
    end
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run not finished, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (lock !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: lock=%b expected=0", lock);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (lock !== 1'b0) begin
      bad++;
      $display("FAIL R1 after release: lock=%b expected=0", lock);
    end

    // R2 R4: four small samples keep unlocked, fifth locks
    compare(1'b1, 0, "R2 coincident, run 1");
    compare(1'b1, 5, "R3 err=5 small, run 2");
    compare(1'b0, 3, "R2 fb leads, run 3");
    compare(1'b1, 1, "R2 ref leads err=1, run 4");
    compare(1'b0, 5, "R4 fifth small locks");
    // R6: band between thresholds and small errors keep lock
    compare(1'b1, 6, "R6 err=6 keeps lock");
    compare(1'b0, 9, "R6 err=9 keeps lock");
    compare(1'b1, 2, "R6 small keeps lock");
    // R7: err=10 drops lock
    compare(1'b1, 10, "R7 err=10 drops lock");
    // R5 R11: four small, middling resets run, then five needed
    compare(1'b1, 1, "R11 run 1");
    compare(1'b1, 2, "R11 run 2");
    compare(1'b0, 3, "R11 run 3");
    compare(1'b1, 4, "R11 run 4");
    compare(1'b1, 6, "R5 err=6 clears run");
    compare(1'b1, 0, "R5 run 1");
    compare(1'b0, 2, "R5 run 2");
    compare(1'b1, 3, "R5 run 3");
    compare(1'b0, 4, "R5 run 4");
    compare(1'b1, 5, "R5 R4 fifth after reset of run locks");
    // R8: lone edge times out, drops lock
    lone_edge("R8 timeout drops lock");
    compare(1'b1, 0, "R8 detector idle again, run 1");
    // R9: repeat lead while unlocked mid-run, then relock
    compare(1'b1, 1, "R9 run 2");
    repeat_lead("R9 unlocked");
    compare(1'b1, 1, "R9 run 2 after restart");
    compare(1'b1, 1, "R9 run 3");
    compare(1'b1, 1, "R9 run 4");
    compare(1'b1, 1, "R9 run 5 locks");
    repeat_lead("R9 locked");
    // R10: long idle leaves lock unchanged
    repeat (20) @(negedge clk);
    push("R10 idle hold");
    repeat (4) @(negedge clk);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule